// File: doc/BRIEF.md
# Byte Transfer Master with Acknowledge-Driven Port Sizing

This block runs single-byte read and write cycles on a 16-bit external data bus whose slaves may be either 8 or 16 bits wide. The width of the addressed port is not known when the cycle starts. The slave reports it by how it drives two active-low acknowledge wires. For that reason a write byte goes out on both halves of the bus. On a read, the byte lane is chosen only after the acknowledge has been seen.

On the internal side there is a request (address, read flag, write byte) with a ready signal. The results come back as a read byte and a one-cycle done pulse. On the external side the block drives the address, a two-bit size code, the address and data strobes, the direction and the 16-bit write data with its enable. It receives the 16-bit read data and the two acknowledge lines.

The acknowledge lines are asynchronous, so they pass through a two-flop synchronizer. The block inserts wait states for as long as no acknowledge arrives. A new request is taken only after the bus has fully returned to idle.

Top module: `dsz_byte_master`

## Requirements
- R1: After reset, both strobes are high, the write-data enable is low, done is low and ready is high.
- R2: While the address strobe is low, the size code is 2'b01, which means a single byte.
- R3: During a write cycle the write enable is high and the write byte appears on both data[15:8] and data[7:0]. During a read cycle the write enable stays low.
- R4: The acknowledge pins ack_n = {wide, narrow} = 2'b10 mean an 8-bit port. A read from such a port returns data[15:8], whether the address is odd or even.
- R5: An acknowledge with ack_n[1] = 0 means a 16-bit port, and the level of ack_n[0] is ignored. A read from an even address on such a port returns data[15:8].
- R6: A read from an odd address on a 16-bit port returns data[7:0].
- R7: While ack_n = 2'b11 the strobes stay low without limit. Address, size code and write data stay unchanged during that time.
- R8: The acknowledges go through two synchronizing flops. In the cycle after a valid synchronized acknowledge, the read byte is captured and the strobes are released. Done is high in the first cycle with the strobes high.
- R9: Ready returns only after the strobes have been high for at least one clock and both synchronized acknowledges are high. A request made while ready is low is ignored.
- R10: Done is high for exactly one clock for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Byte address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wbyte | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Byte read by the last read |
| bus_addr | output | AW | External address |
| bus_siz | output | 2 | Size code |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rd | output | 1 | Direction, 1 = read |
| bus_dout | output | 16 | Write data |
| bus_doe | output | 1 | Write data enable |
| bus_din | input | 16 | Read data |
| ack_n | input | 2 | {wide, narrow} acknowledge, active low |

## Verification
Two situations are hardest to produce from the ports. The first is a slave that keeps its acknowledge asserted after the block has finished the cycle. The second is a request that arrives during that window. The scoreboarded slave model holds the acknowledge for several clocks after done and drives a stray request meanwhile. It checks that the strobes stay high and ready stays low until the acknowledge lines are released. Long wait-state stretches run with the strobes held. Reads from 16-bit ports use different bytes on the two lanes, so a wrong lane choice or a wrong width decode changes the result.

// File: rtl/dsz_pkg.sv
package dsz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_LATCH   = 2'd2,
    ST_RECOVER = 2'd3
  } dsz_state_e;

  localparam logic [1:0] SIZ_BYTE = 2'b01;

  // ack_s is {wide, narrow}, active low, already synchronized
  function automatic logic ack_valid(input logic [1:0] ack_s);
    return (ack_s[1] == 1'b0) || (ack_s == 2'b10);
  endfunction

  function automatic logic ack_wide(input logic [1:0] ack_s);
    return ack_s[1] == 1'b0;
  endfunction

  // byte lane choice once the port width is known
  function automatic logic [7:0] pick_lane(input logic [15:0] d,
                                           input logic port16,
                                           input logic a0);
    return (port16 && a0) ? d[7:0] : d[15:8];
  endfunction

  function automatic logic [15:0] spread_byte(input logic [7:0] b);
    return {b, b};
  endfunction
endpackage

// File: rtl/dsz_ack_sync.sv
module dsz_ack_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dsz_lane.sv
module dsz_lane (
  input  logic [15:0] din,
  input  logic        port16,
  input  logic        a0,
  input  logic [7:0]  wbyte,
  output logic [7:0]  rbyte,
  output logic [15:0] dout
);
  import dsz_pkg::*;
  assign rbyte = pick_lane(din, port16, a0);
  assign dout  = spread_byte(wbyte);
endmodule

// File: rtl/dsz_byte_master.sv
module dsz_byte_master #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_rd,
  input  logic [7:0]    req_wbyte,
  output logic          done,
  output logic [7:0]    rd_byte,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic          bus_as_n,
  output logic          bus_ds_n,
  output logic          bus_rd,
  output logic [15:0]   bus_dout,
  output logic          bus_doe,
  input  logic [15:0]   bus_din,
  input  logic [1:0]    ack_n
);
  import dsz_pkg::*;

  dsz_state_e   state;
  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic [7:0]    wb_q;
  logic          port16_q;
  logic [7:0]    rbyte_q;
  logic          done_q;
  logic [1:0]    ack_s;
  logic [7:0]    lane_byte;
  logic [15:0]   lane_dout;

  // named internal events
  logic accept, ack_seen, bus_quiet, cycle_on;

  dsz_ack_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ack_n), .sync_out(ack_s)
  );

  dsz_lane u_lane (
    .din(bus_din), .port16(port16_q), .a0(addr_q[0]), .wbyte(wb_q),
    .rbyte(lane_byte), .dout(lane_dout)
  );

  assign cycle_on  = (state == ST_STROBE) || (state == ST_LATCH);
  assign accept    = (state == ST_IDLE) && req_valid;
  assign ack_seen  = (state == ST_STROBE) && ack_valid(ack_s);
  assign bus_quiet = (ack_s == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      rd_q     <= 1'b1;
      wb_q     <= '0;
      port16_q <= 1'b0;
      rbyte_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          addr_q <= req_addr;
          rd_q   <= req_rd;
          wb_q   <= req_wbyte;
          state  <= ST_STROBE;
        end
        ST_STROBE: if (ack_seen) begin
          port16_q <= ack_wide(ack_s);
          state    <= ST_LATCH;
        end
        ST_LATCH: begin
          if (rd_q) rbyte_q <= lane_byte;
          done_q <= 1'b1;
          state  <= ST_RECOVER;
        end
        ST_RECOVER: if (bus_quiet) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign done      = done_q;
  assign rd_byte   = rbyte_q;
  assign bus_addr  = addr_q;
  assign bus_siz   = cycle_on ? SIZ_BYTE : 2'b00;
  assign bus_as_n  = !cycle_on;
  assign bus_ds_n  = !cycle_on;
  assign bus_rd    = rd_q;
  assign bus_dout  = lane_dout;
  assign bus_doe   = cycle_on && !rd_q;

  // R2: byte size code whenever the address strobe is active
  a_r2_siz_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> bus_siz == 2'b01);

  // R3: write data replicated on both lanes while driven; never driven on reads
  a_r3_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_dout[15:8] == bus_dout[7:0]) && !bus_rd);

  // R7: address and write data stable through wait states
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_dout)));

  // R8: done only on the first cycle after the strobes are released
  a_r8_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_as_n && $past(!bus_as_n)));

  // R9: ready only after the strobes were released and the acknowledges are quiet
  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(bus_as_n) && $past(bus_quiet)));

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/dsz_byte_master_test.sv
module dsz_byte_master_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_rd = 1'b0;
  logic [7:0]    req_wbyte = '0;
  logic          done;
  logic [7:0]    rd_byte;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic          bus_as_n, bus_ds_n, bus_rd, bus_doe;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din = '0;
  logic [1:0]    ack_n = 2'b11;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  typedef struct { bit is_rd; logic [7:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  dsz_byte_master #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .req_wbyte(req_wbyte),
    .done(done), .rd_byte(rd_byte), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_rd(bus_rd),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .ack_n(ack_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(0, "R10 unexpected done", 1, 0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (it.is_rd) check(rd_byte == it.exp, it.tag, rd_byte, it.exp);
      end
    end
  end

  // one byte transfer with a slave model
  task automatic xfer(input bit rd, input logic [AW-1:0] a, input logic [7:0] wb,
                      input logic [1:0] ack_code, input int waits,
                      input logic [15:0] din, input logic [7:0] exp, input string tag);
    int t;
    sb_item_t it;
    t = 0;
    while (!req_ready && t < 50) begin @(negedge clk); t++; end
    req_valid = 1'b1; req_addr = a; req_rd = rd; req_wbyte = wb;
    @(negedge clk);
    req_valid = 1'b0; req_wbyte = ~wb; req_addr = ~a;
    check(!bus_as_n && bus_siz == 2'b01, "R2 size code during cycle", {bus_as_n, bus_siz}, 3'b001);
    check(bus_addr == a, "R7 address driven", bus_addr, a);
    if (!rd) check(bus_doe && bus_dout == {wb, wb}, "R3 write replicated", {bus_doe, bus_dout}, {1'b1, wb, wb});
    else     check(!bus_doe, "R3 no drive on read", bus_doe, 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      if (i == waits - 1)
        check(!bus_as_n && bus_addr == a && bus_siz == 2'b01 && (rd || bus_dout == {wb, wb}),
              "R7 held through wait states", {bus_as_n, bus_addr}, {1'b0, a});
    end
    it.is_rd = rd; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_din = din; ack_n = ack_code;
    t = 0;
    while (!done && t < 20) begin @(negedge clk); t++; end
    check(done, "R8 done seen", done, 1);
    check(bus_as_n && bus_ds_n, "R8 strobes released at done", {bus_as_n, bus_ds_n}, 2'b11);
    bus_din = 16'h0;
    // slave keeps acknowledging; a stray request must be ignored
    req_valid = 1'b1; req_addr = 24'h00ABCD; req_rd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!req_ready && bus_as_n, "R9 held off while ack asserted", {req_ready, bus_as_n}, 2'b01);
      check(!done, "R10 single pulse", done, 0);
    end
    req_valid = 1'b0;
    ack_n = 2'b11;
    t = 0;
    while (!req_ready && t < 8) begin @(negedge clk); t++; end
    check(req_ready && t >= 2, "R9 ready after ack release", {req_ready, t[7:0]}, 1);
    check(bus_as_n, "R9 stray request not started", bus_as_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bus_as_n && bus_ds_n && !bus_doe && !done && req_ready, "R1 reset state",
          {bus_as_n, bus_ds_n, bus_doe, done, req_ready}, 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(1, 24'h000100, 8'h00, 2'b10, 0, 16'hA55A, 8'hA5, "R4 8-bit even");
    xfer(1, 24'h000101, 8'h00, 2'b10, 2, 16'h3CC3, 8'h3C, "R4 8-bit odd");
    xfer(1, 24'h000200, 8'h00, 2'b01, 1, 16'h7E81, 8'h7E, "R5 16-bit even, narrow high");
    xfer(1, 24'h000202, 8'h00, 2'b00, 0, 16'h1299, 8'h12, "R5 16-bit even, narrow low");
    xfer(1, 24'h000203, 8'h00, 2'b01, 3, 16'h66D4, 8'hD4, "R6 16-bit odd");
    xfer(1, 24'h000205, 8'h00, 2'b00, 0, 16'hF00F, 8'h0F, "R6 16-bit odd both low");
    xfer(0, 24'h000301, 8'hC7, 2'b10, 1, 16'h0000, 8'h00, "R3 write to 8-bit");
    xfer(0, 24'h000302, 8'h5E, 2'b01, 0, 16'h0000, 8'h00, "R3 write to 16-bit");
    xfer(1, 24'h000401, 8'h00, 2'b01, 40, 16'hBE42, 8'h42, "R7 long wait then odd read");
    check(sb_q.size() == 0, "R10 one done per request", sb_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule